// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer with Row-Boundary Stalls

This block sits on the memory side of a synchronous burst read port. The host drives the address-valid strobe low for one clock together with a starting word address while chip-enable is low. The sequencer latches the address, waits a fixed access latency and then presents one word per clock at consecutive addresses for as long as the strobe stays high and both enables stay low.

The storage is organised in groups of 2^GROUP_LOG2 words (128 by default). When the burst steps off the last word of a group, the sequencer does not present the next word at once. It inserts a fresh access latency of the same length as the first access, showing no valid data during it. The address keeps counting linearly and wraps from the top of the address space to zero, which also counts as a group change. A ready output tells the host when data can be taken. A configuration input selects whether ready marks the data cycle itself or the cycle before it. A fixed pattern stands in for the array: each word's value is the address XORed with a constant.

Top module: `burst_read_seq`

## Requirements
- R1: While rst_n is low at a clock edge, and after it, rd_valid and rdy are 0 until a burst is started.
- R2: An address is latched at a clock edge where ce_n = 0 and adv_n = 0. The first word appears after the LATENCY-th following edge. It has rd_valid = 1, rd_addr = the start address and rd_data = the low DATA_W bits of rd_addr XOR PATTERN.
- R3: While ce_n = 0 and adv_n = 1, every clock edge in the data phase advances rd_addr by exactly 1. This gives one valid word per clock within a group.
- R4: After a word whose low GROUP_LOG2 address bits are all 1, the next LATENCY cycles show rd_valid = 0. The word at the next address follows them.
- R5: The address counts past all ones to zero. That step is a group change and takes the same LATENCY-cycle stall as R4.
- R6: With cfg_rdy_lead = 0, rdy equals rd_valid in every cycle.
- R7: With cfg_rdy_lead = 1 and inputs steady, rdy is 1 in a cycle exactly when the following cycle carries a valid word. This covers the last stall cycle and every data cycle that is not the last word of a group.
- R8: ce_n = 1 at a clock edge ends the burst. rd_valid and rdy are then 0, and they stay 0 after ce_n returns low until a new address is latched.
- R9: oe_n = 1 forces rd_valid and rdy to 0 in the same cycle. Lowering oe_n again shows the word of the current cycle.
- R10: A new address latch during a burst abandons it and restarts the full LATENCY wait from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; high aborts the burst |
| oe_n | input | 1 | Output enable, active low; masks valid and ready |
| adv_n | input | 1 | Address-valid strobe, active low; latches start_addr |
| start_addr | input | ADDR_W | Word address of the first word |
| cfg_rdy_lead | input | 1 | 0: ready with data; 1: ready one cycle ahead of data |
| rd_addr | output | ADDR_W | Address of the word being presented |
| rd_data | output | DATA_W | Word value (address pattern) |
| rd_valid | output | 1 | rd_data holds a valid word this cycle |
| rdy | output | 1 | Ready handshake to the host |

## Verification
The bench builds the sequencer with an 8-bit address, groups of 8 words and a latency of 3 clocks. Group crossings therefore come every few words, and the wrap from 0xFF to 0x00 is reached within a short burst. Several crossings, the wrap, both ready timings, an abort, output masking and a mid-burst restart all fit in a few hundred cycles. The same logic serves the default 128-word grouping, because only the group mask width changes.

// File: rtl/burst_seq_pkg.sv
// Shared types for the burst read sequencer.
package burst_seq_pkg;

    // Sequencer phase: idle, access wait (first word or boundary stall), data streaming
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_WAIT   = 2'd1,
        SEQ_STREAM = 2'd2
    } seq_state_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
// Phase controller for the burst read sequencer.
// Does: tracks idle / access-wait / streaming, counts the access latency for the
//       first word and for every group-boundary stall, aborts on chip-enable high.
// Assumes: LATENCY >= 1; group_end is valid for the address currently presented.
module burst_seq_ctrl
    import burst_seq_pkg::*;
#(
    parameter int LATENCY = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       adv_n,
    input  logic       group_end,
    output seq_state_t state,
    output logic       wait_last,
    output logic       load,
    output logic       step
);

    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LATENCY - 1);

    logic [CNT_W-1:0] cnt;

    // Purpose: advance the phase and the latency countdown each clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else if (ce_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else if (!adv_n) begin
            state <= SEQ_WAIT;
            cnt   <= RELOAD;
        end else begin
            unique case (state)
                SEQ_WAIT: begin
                    if (cnt == '0) begin
                        state <= SEQ_STREAM;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEQ_STREAM: begin
                    if (group_end) begin
                        state <= SEQ_WAIT;
                        cnt   <= RELOAD;
                    end
                end
                default: begin
                    state <= SEQ_IDLE;
                end
            endcase
        end
    end

    // Purpose: derive strobes for the address counter and the output stage
    always_comb begin
        load      = !ce_n && !adv_n;
        step      = !ce_n && adv_n && (state == SEQ_STREAM);
        wait_last = (state == SEQ_WAIT) && (cnt == '0);
    end

    // R8: chip-enable high at an edge leaves the sequencer idle
    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> state == SEQ_IDLE);

    // R2: a wait that is not finished shortens by one clock per edge
    assert_wait_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WAIT && cnt != '0 && !ce_n && adv_n)
        |=> (state == SEQ_WAIT && cnt == $past(cnt) - 1'b1));

    // R10: a latch during any phase restarts the full wait
    assert_latch_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !adv_n) |=> (state == SEQ_WAIT && cnt == RELOAD));

endmodule

// File: rtl/burst_addr_ctr.sv
// Word address counter for the burst read sequencer.
// Does: loads the start address, then steps linearly by one word, wrapping at the
//       top of the address space; flags the last word of each 2^GROUP_LOG2 group.
// Assumes: load has priority over step; GROUP_LOG2 <= ADDR_W.
module burst_addr_ctr #(
    parameter int ADDR_W     = 24,
    parameter int GROUP_LOG2 = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              group_end
);

    // Purpose: hold the current word address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_addr;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end

    // Purpose: mark the last word before a group boundary
    always_comb begin
        group_end = &addr[GROUP_LOG2-1:0];
    end

    // R2: a latch captures the start address
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == $past(load_addr));

    // R3 / R5: streaming steps by one, wrapping linearly through zero
    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> addr == $past(addr) + 1'b1);

endmodule

// File: rtl/burst_out_stage.sv
// Output stage for the burst read sequencer.
// Does: forms the word value from the address pattern, qualifies it as valid
//       in the data phase, and produces ready either with data or one cycle ahead.
// Assumes: wait_last is high only in the final wait cycle before data.
module burst_out_stage
    import burst_seq_pkg::*;
#(
    parameter int              ADDR_W  = 24,
    parameter int              DATA_W  = 16,
    parameter logic [DATA_W-1:0] PATTERN = 16'hA5C3
) (
    input  seq_state_t        state,
    input  logic              wait_last,
    input  logic              group_end,
    input  logic              oe_n,
    input  logic              lead,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rdy
);

    logic streaming;
    logic next_valid;

    // Purpose: stand-in array read, address mixed with a fixed pattern
    always_comb begin
        rd_data = DATA_W'(addr) ^ PATTERN;
    end

    // Purpose: valid word this cycle, and whether the next cycle will hold one
    always_comb begin
        streaming  = (state == SEQ_STREAM);
        next_valid = wait_last || (streaming && !group_end);
        rd_valid   = streaming && !oe_n;
    end

    // Purpose: pick ready timing from the configuration input
    always_comb begin
        if (lead) begin
            rdy = next_valid && !oe_n;
        end else begin
            rdy = rd_valid;
        end
    end

endmodule

// File: rtl/burst_read_seq.sv
// Synchronous burst read sequencer with row-boundary latency insertion.
// Does: latches a start address on the address-valid strobe, waits LATENCY clocks,
//       streams one word per clock, and re-inserts LATENCY clocks at every
//       2^GROUP_LOG2-word boundary (including the wrap to zero).
// Assumes: synchronous active-low reset; enables and strobe sampled on rising edges.
module burst_read_seq
    import burst_seq_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter int                DATA_W     = 16,
    parameter int                GROUP_LOG2 = 7,
    parameter int                LATENCY    = 5,
    parameter logic [DATA_W-1:0] PATTERN    = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              cfg_rdy_lead,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rdy
);

    seq_state_t state;
    logic       wait_last;
    logic       load;
    logic       step;
    logic       group_end;

    burst_seq_ctrl #(
        .LATENCY (LATENCY)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .adv_n     (adv_n),
        .group_end (group_end),
        .state     (state),
        .wait_last (wait_last),
        .load      (load),
        .step      (step)
    );

    burst_addr_ctr #(
        .ADDR_W     (ADDR_W),
        .GROUP_LOG2 (GROUP_LOG2)
    ) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (start_addr),
        .step      (step),
        .addr      (rd_addr),
        .group_end (group_end)
    );

    burst_out_stage #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PATTERN (PATTERN)
    ) i_out (
        .state     (state),
        .wait_last (wait_last),
        .group_end (group_end),
        .oe_n      (oe_n),
        .lead      (cfg_rdy_lead),
        .addr      (rd_addr),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rdy       (rdy)
    );

    // R4: the last word of a group is followed by a non-valid cycle
    assert_boundary_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && group_end && !ce_n && adv_n) |=> !rd_valid);

    // R6: in with-data mode a valid word always carries ready
    assert_rdy_with_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdy_lead && rd_valid) |-> rdy);

    // R7: in lead mode ready promises a valid word on the next cycle
    assert_rdy_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdy_lead && rdy)
        |=> (rd_valid || $past(ce_n) || !$past(adv_n) || oe_n));

    // R9: output disable hides valid and ready
    assert_oe_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!rd_valid && !rdy));

endmodule

// File: tb/test_burst_read_seq.sv
// Directed bench for burst_read_seq: one task per scenario, each checking itself.
module test_burst_read_seq;

    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int GL  = 3;
    localparam int LAT = 3;
    localparam logic [DW-1:0] PAT = 16'hA5C3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n;
    logic          oe_n;
    logic          adv_n;
    logic [AW-1:0] start_addr;
    logic          cfg_rdy_lead;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          rdy;

    int vectors     = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    burst_read_seq #(
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .GROUP_LOG2 (GL),
        .LATENCY    (LAT),
        .PATTERN    (PAT)
    ) i_burst_read_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce_n         (ce_n),
        .oe_n         (oe_n),
        .adv_n        (adv_n),
        .start_addr   (start_addr),
        .cfg_rdy_lead (cfg_rdy_lead),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .rdy          (rdy)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic go_idle();
        ce_n  = 1'b1;
        adv_n = 1'b1;
        oe_n  = 1'b0;
        tick();
    endtask

    // Latch start, then check n samples against a model built from R2..R7.
    // Ends at the sample point of the last checked cycle.
    task automatic run_burst(input logic [AW-1:0] start, input logic lead,
                             input int n, input string tag);
        logic          ev [0:127];
        logic [AW-1:0] ea [0:127];
        logic [AW-1:0] a;
        int            idx;
        idx = 0;
        a   = start;
        for (int i = 0; i < LAT; i++) begin
            ev[idx] = 1'b0; ea[idx] = '0; idx++;
        end
        while (idx < n + 1) begin
            ev[idx] = 1'b1; ea[idx] = a; idx++;
            if (&a[GL-1:0]) begin
                for (int i = 0; i < LAT; i++) begin
                    if (idx < 128) begin
                        ev[idx] = 1'b0; ea[idx] = '0; idx++;
                    end
                end
            end
            a = a + 1'b1;
        end
        ce_n         = 1'b0;
        oe_n         = 1'b0;
        adv_n        = 1'b0;
        start_addr   = start;
        cfg_rdy_lead = lead;
        tick();
        adv_n = 1'b1;
        for (int i = 0; i < n; i++) begin
            chk({tag, " valid"}, 32'(rd_valid), 32'(ev[i]));
            chk({tag, " rdy"}, 32'(rdy), lead ? 32'(ev[i+1]) : 32'(ev[i]));
            if (ev[i]) begin
                chk({tag, " addr"}, 32'(rd_addr), 32'(ea[i]));
                chk({tag, " data"}, 32'(rd_data), 32'(DW'(ea[i]) ^ PAT));
            end
            if (i < n - 1) tick();
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b0; adv_n = 1'b1;
        start_addr = '0; cfg_rdy_lead = 1'b0;
        repeat (3) tick();
        chk("R1 valid in reset", 32'(rd_valid), 32'd0);
        chk("R1 rdy in reset", 32'(rdy), 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 valid after reset", 32'(rd_valid), 32'd0);
        chk("R1 rdy after reset", 32'(rdy), 32'd0);
    endtask

    task automatic t_first_word();   // R2, R3, R6
        run_burst(8'h40, 1'b0, LAT + 6, "R2/R3");
        go_idle();
    endtask

    task automatic t_boundary_with_data();   // R4, R6
        run_burst(8'h05, 1'b0, 24, "R4/R6");
        go_idle();
    endtask

    task automatic t_boundary_lead();   // R7
        run_burst(8'h2D, 1'b1, 24, "R7");
        go_idle();
    endtask

    task automatic t_wrap();   // R5
        run_burst(8'hFA, 1'b0, 16, "R5");
        go_idle();
        run_burst(8'hFE, 1'b1, 10, "R5 lead");
        go_idle();
    endtask

    task automatic t_abort();   // R8
        run_burst(8'h30, 1'b1, LAT + 2, "R8 pre");
        ce_n = 1'b1;
        tick();
        chk("R8 valid after abort", 32'(rd_valid), 32'd0);
        chk("R8 rdy after abort", 32'(rdy), 32'd0);
        ce_n  = 1'b0;
        adv_n = 1'b1;
        repeat (2 * LAT + 2) tick();
        chk("R8 valid stays low", 32'(rd_valid), 32'd0);
        chk("R8 rdy stays low", 32'(rdy), 32'd0);
        go_idle();
    endtask

    task automatic t_oe_mask();   // R9
        run_burst(8'h10, 1'b1, LAT + 2, "R9 pre");
        oe_n = 1'b1;
        #1;
        chk("R9 valid masked", 32'(rd_valid), 32'd0);
        chk("R9 rdy masked", 32'(rdy), 32'd0);
        oe_n = 1'b0;
        #1;
        chk("R9 valid restored", 32'(rd_valid), 32'd1);
        chk("R9 addr restored", 32'(rd_addr), 32'h11);
        go_idle();
    endtask

    task automatic t_restart();   // R10
        run_burst(8'h20, 1'b0, LAT + 3, "R10 pre");
        run_burst(8'h44, 1'b0, 12, "R10");
        go_idle();
    endtask

    initial begin
        t_reset();
        t_first_word();
        t_boundary_with_data();
        t_boundary_lead();
        t_wrap();
        t_abort();
        t_oe_mask();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule